// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the type-0 configuration header of one PCI function: identity and class codes, command and status, cache line size, latency timer, interrupt routing bytes, six base address registers (BARs) and the expansion ROM base. Host software reaches it through a small request/response port. Each request carries a read/write flag, a byte offset, an access size of 1, 2 or 4 bytes and, for writes, a data word. The response comes back a fixed number of cycles later. Every identity value and every reset value is a parameter.

The BARs support the usual sizing handshake. Writing all ones makes a BAR read back a mask built from its power-of-two size parameter, with its type bits kept. Writing a real base records a decoded window address, which is the written base plus a fixed I/O or memory window offset. It also raises a one-cycle range-change pulse so the fabric can update its decoders. The expansion ROM base has its own probe value. A BAR size parameter that is neither zero nor a power of two stops elaboration.

The port handles one access at a time. Accesses beyond the 64-byte header, and illegal sizes, complete with an error response. Writes to header locations that are not writable are flagged, except for a small set of read-only bytes whose writes are quietly dropped.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `wr_err` and `range_chg` are 0, every `bar_base` slot is 0, and reads return the parameter reset values at the standard header offsets (vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, class bytes 0x09-0x0B, BARs 0x10-0x24, ROM 0x30, interrupt line/pin 0x3C/0x3D, min grant 0x3E, max latency 0x3F).
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the one cycle that follows the CFG_DELAY-th rising edge after acceptance. `rsp_valid`, `wr_err` and `range_chg` are 0 in every other cycle.
- R3: `req_size` holds the byte count. A read of size 1, 2 or 4 at offset o returns header byte o+j in bits 8j+7:8j of `rsp_rdata`. Bytes at or above 0x40 read as 0. Unrequested upper bytes are 0. Write responses carry data 0.
- R4: Size-1 writes at 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer) store the low data byte.
- R5: Size-1 writes at 0x3D, 0x3E, 0x3F, 0x0B and 0x08 change nothing and do not raise `wr_err`.
- R6: Size-2 writes at 0x04 and 0x06 store the low halfword into command or status. A size-4 write at 0x04 stores its low halfword into command and leaves status unchanged.
- R7: Any other write inside the header (offset below 0x40, legal size) changes nothing and raises `wr_err` in the response cycle, with `rsp_err` at 0.
- R8: A size-4 write of 0xFFFFFFFF to BAR k (offset 0x10+4k) makes it read ~(size_k-1) in its address bits with its type bits kept, where size 0 gives address bits 0. `bar_base` does not change and no `range_chg` is raised.
- R9: Bit 0 of a BAR selects I/O type (type bits [1:0]) or memory type (type bits [3:0]). Type bits never change. Any other size-4 BAR write stores the data's address bits. If those bits are nonzero, `bar_base` slot k becomes address bits + IO_WINDOW or + MEM_WINDOW, and `range_chg` is 1 in the response cycle.
- R10: A size-4 write at 0x30 stores 0xFFFFFFFF when the data is 0xFFFFFFFE. Any other value is stored unchanged.
- R11: An access at offset 0x40 or above, or with a size other than 1, 2 or 4, responds with `rsp_err`=1 and data 0, changes nothing, and does not raise `wr_err`.
- R12: While an access is outstanding, `req_ready` is 0 and `req_valid` is not accepted. The ignored request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when no access is outstanding |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, little-endian from the offset |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Unsupported offset or illegal size |
| rsp_rdata | output | 32 | Read data |
| wr_err | output | 1 | Write to a protected header location |
| range_chg | output | 1 | A BAR window changed |
| bar_base | output | 192 | Decoded window base of each BAR, 32 bits per BAR, BAR k in bits 32k+31:32k |

## Verification
The bound assertions watch, on every cycle, the fixed response latency and its one-cycle width. They also check that `req_ready` drops once a request is taken, that error responses carry zero data, that `wr_err` and `range_chg` appear only with a response, and that no BAR type bit ever moves. Only the bench's scenarios can show the values themselves. These are the probe masks per BAR size and type, the window arithmetic, the ROM probe substitution, the bytes that writes to protected locations leave intact, and the ignoring of a request presented while busy.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NUM_BAR   = 6;
  localparam int DW        = 32;
  localparam int OFF_W     = 8;
  localparam int SIZE_W    = 3;
  localparam int HDR_BYTES = 64;
  localparam int HDR_AW    = $clog2(HDR_BYTES);

  // header offsets that software decodes
  localparam logic [OFF_W-1:0] OFF_CMD      = 8'h04;
  localparam logic [OFF_W-1:0] OFF_STATUS   = 8'h06;
  localparam logic [OFF_W-1:0] OFF_REV      = 8'h08;
  localparam logic [OFF_W-1:0] OFF_CLASS    = 8'h0B;
  localparam logic [OFF_W-1:0] OFF_CLS      = 8'h0C;
  localparam logic [OFF_W-1:0] OFF_LAT      = 8'h0D;
  localparam logic [OFF_W-1:0] OFF_BAR0     = 8'h10;
  localparam logic [OFF_W-1:0] OFF_ROM      = 8'h30;
  localparam logic [OFF_W-1:0] OFF_INT_LINE = 8'h3C;
  localparam logic [OFF_W-1:0] OFF_INT_PIN  = 8'h3D;
  localparam logic [OFF_W-1:0] OFF_MIN_GNT  = 8'h3E;
  localparam logic [OFF_W-1:0] OFF_MAX_LAT  = 8'h3F;

  typedef logic [NUM_BAR-1:0][DW-1:0] bar_vec_t;

  // low bits of a BAR that hold its type and never take written data
  function automatic logic [DW-1:0] bar_type_mask(input logic [DW-1:0] cur);
    return cur[0] ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  // value a BAR presents after an all-ones probe
  function automatic logic [DW-1:0] bar_probe_value(input logic [DW-1:0] size);
    return ~(size - 32'd1);
  endfunction

  function automatic logic [DW-1:0] rom_store_value(input logic [DW-1:0] wd);
    return (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd;
  endfunction

  function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic pow2_or_zero(input logic [DW-1:0] v);
    return (v & (v - 32'd1)) == '0;
  endfunction

endpackage

// File: rtl/cfg_port_seq.sv
module cfg_port_seq
  import cfg_hdr_pkg::*;
#(
  parameter int CFG_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              commit,
  output logic              lat_write,
  output logic [OFF_W-1:0]  lat_offset,
  output logic [SIZE_W-1:0] lat_size,
  output logic [DW-1:0]     lat_wdata
);

  localparam int CNT_W = (CFG_DELAY < 2) ? 1 : $clog2(CFG_DELAY + 1);

  if (CFG_DELAY < 1) begin : g_bad_delay
    $error("cfg_port_seq: CFG_DELAY must be at least 1");
  end

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign commit    = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      lat_write  <= 1'b0;
      lat_offset <= '0;
      lat_size   <= '0;
      lat_wdata  <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      cnt_q      <= CNT_W'(CFG_DELAY - 1);
      lat_write  <= req_write;
      lat_offset <= req_offset;
      lat_size   <= req_size;
      lat_wdata  <= req_wdata;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter logic [DW-1:0] SIZE    = 32'h0000_1000,
  parameter logic [DW-1:0] INIT    = 32'h0000_0000,
  parameter logic [DW-1:0] IO_WIN  = 32'h8000_0000,
  parameter logic [DW-1:0] MEM_WIN = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bar_q,
  output logic [DW-1:0] base_q,
  output logic          rng_pulse
);

  if (!pow2_or_zero(SIZE)) begin : g_bad_size
    $error("cfg_bar_slot: BAR size must be zero or a power of two");
  end

  logic [DW-1:0] type_mask;
  logic          is_probe;
  logic [DW-1:0] new_val;
  logic [DW-1:0] addr_bits;
  logic          take_base;

  assign type_mask = bar_type_mask(bar_q);
  assign is_probe  = (wdata == '1);
  assign new_val   = is_probe ? bar_probe_value(SIZE) : wdata;
  assign addr_bits = new_val & ~type_mask;
  assign take_base = !is_probe && (addr_bits != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q     <= INIT;
      base_q    <= '0;
      rng_pulse <= 1'b0;
    end else begin
      rng_pulse <= wr_en && take_base;
      if (wr_en) begin
        bar_q <= addr_bits | (bar_q & type_mask);
        if (take_base) base_q <= addr_bits + (bar_q[0] ? IO_WIN : MEM_WIN);
      end
    end
  end

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int             CFG_DELAY     = 2,
  parameter logic [15:0]    VENDOR_ID     = 16'h1D0F,
  parameter logic [15:0]    DEVICE_ID     = 16'h0042,
  parameter logic [7:0]     REVISION      = 8'h03,
  parameter logic [7:0]     PROG_IF       = 8'h00,
  parameter logic [7:0]     SUB_CLASS     = 8'h00,
  parameter logic [7:0]     CLASS_CODE    = 8'h02,
  parameter logic [7:0]     HEADER_TYPE   = 8'h00,
  parameter logic [7:0]     BIST_VAL      = 8'h00,
  parameter logic [15:0]    CMD_INIT      = 16'h0000,
  parameter logic [15:0]    STATUS_INIT   = 16'h0010,
  parameter logic [7:0]     CLS_INIT      = 8'h00,
  parameter logic [7:0]     LAT_INIT      = 8'h00,
  parameter logic [DW-1:0]  CIS_PTR       = 32'h0000_0000,
  parameter logic [15:0]    SUBSYS_VENDOR = 16'h1D0F,
  parameter logic [15:0]    SUBSYS_ID     = 16'h0001,
  parameter logic [DW-1:0]  ROM_INIT      = 32'h0000_0000,
  parameter logic [7:0]     INT_LINE_INIT = 8'h0B,
  parameter logic [7:0]     INT_PIN       = 8'h01,
  parameter logic [7:0]     MIN_GNT       = 8'h04,
  parameter logic [7:0]     MAX_LAT       = 8'h10,
  parameter bar_vec_t       BAR_SIZE      = {32'h0000_0010, 32'h0, 32'h0010_0000,
                                             32'h0, 32'h0000_1000, 32'h0000_0100},
  parameter bar_vec_t       BAR_INIT      = {32'h0, 32'h0, 32'h0000_0008,
                                             32'h0, 32'h0, 32'h0000_0001},
  parameter logic [DW-1:0]  IO_WINDOW     = 32'h8000_0000,
  parameter logic [DW-1:0]  MEM_WINDOW    = 32'h4000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [OFF_W-1:0]      req_offset,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  wr_err,
  output logic                  range_chg,
  output logic [NUM_BAR*DW-1:0] bar_base
);

  // ---------------- access sequencing (R2, R12)
  logic              commit;
  logic              lat_write;
  logic [OFF_W-1:0]  lat_offset;
  logic [SIZE_W-1:0] lat_size;
  logic [DW-1:0]     lat_wdata;

  cfg_port_seq #(.CFG_DELAY(CFG_DELAY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_offset (req_offset),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .commit     (commit),
    .lat_write  (lat_write),
    .lat_offset (lat_offset),
    .lat_size   (lat_size),
    .lat_wdata  (lat_wdata)
  );

  // ---------------- decode of the latched request
  logic               bad_acc;
  logic               byte_rw, byte_ro, half_ok, word_cmd, rom_hit, wr_ok, do_wr;
  logic [NUM_BAR-1:0] bar_hit;

  assign bad_acc  = (lat_offset >= OFF_W'(HDR_BYTES)) || !size_legal(lat_size);
  assign byte_rw  = (lat_size == 3'd1) &&
                    ((lat_offset == OFF_INT_LINE) || (lat_offset == OFF_CLS) ||
                     (lat_offset == OFF_LAT));
  assign byte_ro  = (lat_size == 3'd1) &&
                    ((lat_offset == OFF_INT_PIN) || (lat_offset == OFF_MIN_GNT) ||
                     (lat_offset == OFF_MAX_LAT) || (lat_offset == OFF_CLASS) ||
                     (lat_offset == OFF_REV));
  assign half_ok  = (lat_size == 3'd2) &&
                    ((lat_offset == OFF_CMD) || (lat_offset == OFF_STATUS));
  assign word_cmd = (lat_size == 3'd4) && (lat_offset == OFF_CMD);
  assign rom_hit  = (lat_size == 3'd4) && (lat_offset == OFF_ROM);

  always_comb begin
    for (int k = 0; k < NUM_BAR; k++)
      bar_hit[k] = (lat_size == 3'd4) && (lat_offset == OFF_BAR0 + OFF_W'(4 * k));
  end

  assign wr_ok = byte_rw || byte_ro || half_ok || word_cmd || rom_hit || (|bar_hit);
  assign do_wr = commit && lat_write && !bad_acc;

  // ---------------- writable scalar registers (R4, R6, R10)
  logic [15:0]   cmd_q, status_q;
  logic [7:0]    cls_q, lat_q, int_line_q;
  logic [DW-1:0] rom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= CMD_INIT;
      status_q   <= STATUS_INIT;
      cls_q      <= CLS_INIT;
      lat_q      <= LAT_INIT;
      int_line_q <= INT_LINE_INIT;
      rom_q      <= ROM_INIT;
    end else if (do_wr) begin
      if (byte_rw) begin
        case (lat_offset)
          OFF_INT_LINE: int_line_q <= lat_wdata[7:0];
          OFF_CLS:      cls_q      <= lat_wdata[7:0];
          default:      lat_q      <= lat_wdata[7:0];
        endcase
      end
      if (half_ok) begin
        if (lat_offset == OFF_CMD) cmd_q    <= lat_wdata[15:0];
        else                       status_q <= lat_wdata[15:0];
      end
      if (word_cmd) cmd_q <= lat_wdata[15:0];
      if (rom_hit)  rom_q <= rom_store_value(lat_wdata);
    end
  end

  // ---------------- base address registers (R8, R9)
  bar_vec_t               bar_q;
  bar_vec_t               base_q;
  logic [NUM_BAR-1:0]     rng_pulse;
  logic [2*NUM_BAR-1:0]   bar_type_bits;

  for (genvar k = 0; k < NUM_BAR; k++) begin : g_bar
    cfg_bar_slot #(
      .SIZE    (BAR_SIZE[k]),
      .INIT    (BAR_INIT[k]),
      .IO_WIN  (IO_WINDOW),
      .MEM_WIN (MEM_WINDOW)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (do_wr && bar_hit[k]),
      .wdata     (lat_wdata),
      .bar_q     (bar_q[k]),
      .base_q    (base_q[k]),
      .rng_pulse (rng_pulse[k])
    );
    assign bar_base[DW*k +: DW]     = base_q[k];
    assign bar_type_bits[2*k +: 2]  = bar_q[k][1:0];
  end

  // ---------------- header image and read path (R1, R3)
  logic [HDR_BYTES-1:0][7:0] img;
  logic [DW-1:0]             rd_word;

  always_comb begin
    img = '0;
    {img[1],  img[0]}  = VENDOR_ID;
    {img[3],  img[2]}  = DEVICE_ID;
    {img[5],  img[4]}  = cmd_q;
    {img[7],  img[6]}  = status_q;
    img[8]  = REVISION;
    img[9]  = PROG_IF;
    img[10] = SUB_CLASS;
    img[11] = CLASS_CODE;
    img[12] = cls_q;
    img[13] = lat_q;
    img[14] = HEADER_TYPE;
    img[15] = BIST_VAL;
    for (int k = 0; k < NUM_BAR; k++)
      for (int j = 0; j < 4; j++)
        img[16 + 4 * k + j] = bar_q[k][8 * j +: 8];
    {img[43], img[42], img[41], img[40]} = CIS_PTR;
    {img[45], img[44]} = SUBSYS_VENDOR;
    {img[47], img[46]} = SUBSYS_ID;
    {img[51], img[50], img[49], img[48]} = rom_q;
    img[60] = int_line_q;
    img[61] = INT_PIN;
    img[62] = MIN_GNT;
    img[63] = MAX_LAT;
  end

  always_comb begin
    rd_word = '0;
    for (int j = 0; j < 4; j++) begin
      logic [OFF_W:0] idx;
      idx = {1'b0, lat_offset} + (OFF_W+1)'(j);
      if ((SIZE_W'(j) < lat_size) && (idx < (OFF_W+1)'(HDR_BYTES)))
        rd_word[8 * j +: 8] = img[idx[HDR_AW-1:0]];
    end
  end

  // ---------------- response (R2, R7, R11)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      rsp_valid <= commit;
      rsp_err   <= commit && bad_acc;
      rsp_rdata <= (commit && !lat_write && !bad_acc) ? rd_word : '0;
      wr_err    <= do_wr && !wr_ok;
    end
  end

  assign range_chg = |rng_pulse;

endmodule

// File: rtl/cfg_hdr_regs_chk.sv
module cfg_hdr_regs_chk
  import cfg_hdr_pkg::*;
#(
  parameter int CFG_DELAY = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [DW-1:0]        rsp_rdata,
  input logic                 wr_err,
  input logic                 range_chg,
  input logic [2*NUM_BAR-1:0] bar_type_bits
);

  // cycles since acceptance; avoids a parameter-deep $past
  logic [15:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          wait_cnt <= '0;
    else if (req_valid && req_ready)     wait_cnt <= 16'd1;
    else if (rsp_valid)                  wait_cnt <= '0;
    else if (wait_cnt != '0)             wait_cnt <= wait_cnt + 16'd1;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (wait_cnt == 16'(CFG_DELAY + 1)));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && (rsp_rdata == '0)));

  a_r7_werr_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (rsp_valid && !rsp_err));

  a_r9_range_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    range_chg |-> (rsp_valid && !rsp_err && !wr_err));

  a_r9_type_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bar_type_bits));

endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(.CFG_DELAY(CFG_DELAY)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .wr_err        (wr_err),
  .range_chg     (range_chg),
  .bar_type_bits (bar_type_bits)
);

// File: tb/tb_cfg_hdr_regs.sv
module tb_cfg_hdr_regs;
  import cfg_hdr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 3;
  localparam logic [31:0] IOW  = 32'h8000_0000;
  localparam logic [31:0] MEMW = 32'h4000_0000;
  localparam bar_vec_t TB_SIZE = {32'h0000_0010, 32'h0, 32'h0010_0000,
                                  32'h0, 32'h0000_1000, 32'h0000_0100};
  localparam bar_vec_t TB_INIT = {32'h0, 32'h0, 32'h0000_0008,
                                  32'h0, 32'h0, 32'h0000_0001};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_offset = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, wr_err, range_chg;
  logic [31:0] rsp_rdata;
  logic [NUM_BAR*32-1:0] bar_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_regs #(
    .CFG_DELAY(DLY), .VENDOR_ID(16'hBEEF), .DEVICE_ID(16'h0A51), .REVISION(8'h07),
    .PROG_IF(8'h01), .SUB_CLASS(8'h80), .CLASS_CODE(8'h02), .HEADER_TYPE(8'h00),
    .BIST_VAL(8'h00), .CMD_INIT(16'h0000), .STATUS_INIT(16'h0010), .CLS_INIT(8'h00),
    .LAT_INIT(8'h00), .CIS_PTR(32'h0), .SUBSYS_VENDOR(16'hBEEF), .SUBSYS_ID(16'h0001),
    .ROM_INIT(32'h0), .INT_LINE_INIT(8'h0B), .INT_PIN(8'h01), .MIN_GNT(8'h04),
    .MAX_LAT(8'h10), .BAR_SIZE(TB_SIZE), .BAR_INIT(TB_INIT),
    .IO_WINDOW(IOW), .MEM_WINDOW(MEMW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .wr_err(wr_err), .range_chg(range_chg), .bar_base(bar_base)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit run = 0, done = 0;
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model
  logic [7:0]  mdl [64];
  logic [31:0] mbase [NUM_BAR];
  bit pend = 0;
  int due = 0;
  logic [31:0] e_rd;
  bit e_err, e_werr, e_rng;

  function automatic logic [31:0] get32(int o);
    return {mdl[o+3], mdl[o+2], mdl[o+1], mdl[o]};
  endfunction

  task automatic put32(int o, logic [31:0] v);
    for (int j = 0; j < 4; j++) mdl[o+j] = v[8*j +: 8];
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    put32(0, 32'h0A51_BEEF);
    put32(4, 32'h0010_0000);
    put32(8, 32'h0280_0107);
    put32(44, 32'h0001_BEEF);
    put32(60, 32'h1004_010B);
    for (int k = 0; k < NUM_BAR; k++) begin
      put32(16 + 4*k, TB_INIT[k]);
      mbase[k] = 32'h0;
    end
  endtask

  task automatic model_step(bit w, int off, int sz, logic [31:0] wd);
    e_rd = 0; e_err = 0; e_werr = 0; e_rng = 0;
    if (off >= 64 || !(sz == 1 || sz == 2 || sz == 4)) e_err = 1;
    else if (!w) begin
      for (int j = 0; j < sz; j++) if (off + j < 64) e_rd[8*j +: 8] = mdl[off+j];
    end else if (sz == 1) begin
      if (off == 'h3C || off == 'h0C || off == 'h0D) mdl[off] = wd[7:0];
      else if (!(off == 'h3D || off == 'h3E || off == 'h3F || off == 'h0B || off == 'h08))
        e_werr = 1;
    end else if (sz == 2) begin
      if (off == 4 || off == 6) begin mdl[off] = wd[7:0]; mdl[off+1] = wd[15:8]; end
      else e_werr = 1;
    end else begin
      if (off == 4) begin mdl[4] = wd[7:0]; mdl[5] = wd[15:8]; end
      else if (off >= 16 && off <= 36 && off % 4 == 0) begin
        int i;
        logic [31:0] old, lowm, nv;
        i = (off - 16) / 4;
        old = get32(off);
        lowm = old[0] ? 32'd3 : 32'd15;
        if (wd == 32'hFFFF_FFFF) nv = 32'h0 - TB_SIZE[i];
        else nv = wd;
        nv = nv & ~lowm;
        put32(off, nv | (old & lowm));
        if (wd != 32'hFFFF_FFFF && nv != 0) begin
          mbase[i] = nv + (old[0] ? IOW : MEMW);
          e_rng = 1;
        end
      end else if (off == 48) put32(48, (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd);
      else e_werr = 1;
    end
  endtask

  // ---------------- per-clock comparison
  always @(negedge clk) begin
    if (run) begin
      if (pend && cyc == due) begin
        chk(rsp_valid === 1'b1, "rsp_valid (R2)", 32'(rsp_valid), 1);
        chk(rsp_rdata === e_rd, "rsp_rdata", rsp_rdata, e_rd);
        chk(rsp_err === e_err, "rsp_err", 32'(rsp_err), 32'(e_err));
        chk(wr_err === e_werr, "wr_err", 32'(wr_err), 32'(e_werr));
        chk(range_chg === e_rng, "range_chg", 32'(range_chg), 32'(e_rng));
        for (int k = 0; k < NUM_BAR; k++)
          chk(bar_base[32*k +: 32] === mbase[k], "bar_base", bar_base[32*k +: 32], mbase[k]);
        pend = 0;
      end else begin
        chk({rsp_valid, wr_err, range_chg} === 3'b000, "R2 idle strobes",
            32'({rsp_valid, wr_err, range_chg}), 0);
      end
    end
  end

  // ---------------- drivers
  task automatic acc(bit w, int off, int sz, logic [31:0] wd, bit junk = 0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_offset = 8'(off); req_size = 3'(sz); req_wdata = wd;
    model_step(w, off, sz, wd);
    due = cyc + 1 + DLY;
    pend = 1;
    @(negedge clk);
    if (junk) begin
      // R12: hold a competing write while busy; it must not be taken
      for (int k = 0; k < DLY; k++) begin
        req_valid = 1; req_write = 1; req_offset = 8'h3C; req_size = 3'd1; req_wdata = 32'hEE;
        chk(req_ready === 1'b0, "R12 ready while busy", 32'(req_ready), 0);
        @(negedge clk);
      end
    end
    req_valid = 0;
    while (pend) @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;
    tag = "R1";
    chk(req_ready === 1'b1, "req_ready", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "rsp_valid", 32'(rsp_valid), 0);
    chk(bar_base === '0, "bar_base low word", bar_base[31:0], 0);
    acc(0, 'h00, 4, 0); acc(0, 'h04, 4, 0); acc(0, 'h08, 4, 0);
    acc(0, 'h10, 4, 0); acc(0, 'h1C, 4, 0); acc(0, 'h3C, 4, 0); acc(0, 'h2C, 4, 0);

    tag = "R3";
    acc(0, 'h02, 1, 0); acc(0, 'h0A, 2, 0); acc(0, 'h3E, 4, 0); acc(0, 'h3F, 2, 0);
    acc(1, 'h0C, 1, 32'h1234_5608);

    tag = "R4";
    acc(1, 'h3C, 1, 32'hFFFF_FF5A); acc(1, 'h0C, 1, 32'h10); acc(1, 'h0D, 1, 32'h40);
    acc(0, 'h0C, 4, 0); acc(0, 'h3C, 1, 0);

    tag = "R5";
    acc(1, 'h3D, 1, 32'h77); acc(1, 'h3E, 1, 32'h77); acc(1, 'h3F, 1, 32'h77);
    acc(1, 'h0B, 1, 32'h77); acc(1, 'h08, 1, 32'h77);
    acc(0, 'h3C, 4, 0); acc(0, 'h08, 4, 0);

    tag = "R6";
    acc(1, 'h04, 2, 32'h0147); acc(1, 'h06, 2, 32'hABCD); acc(0, 'h04, 4, 0);
    acc(1, 'h04, 4, 32'h1234_0007); acc(0, 'h04, 4, 0);

    tag = "R7";
    acc(1, 'h00, 1, 32'h55); acc(1, 'h0C, 2, 32'h9999); acc(1, 'h28, 4, 32'hDEAD_BEEF);
    acc(1, 'h3C, 4, 32'h1111_1111); acc(1, 'h11, 4, 32'hFFFF_FFFF); acc(1, 'h06, 4, 32'h1);
    acc(0, 'h00, 4, 0); acc(0, 'h0C, 4, 0); acc(0, 'h3C, 4, 0); acc(0, 'h04, 4, 0);

    tag = "R8";
    for (int k = 0; k < NUM_BAR; k++) begin
      acc(1, 16 + 4*k, 4, 32'hFFFF_FFFF);
      acc(0, 16 + 4*k, 4, 0);
    end

    tag = "R9";
    acc(1, 'h14, 4, 32'h1234_5678); acc(0, 'h14, 4, 0);
    acc(1, 'h10, 4, 32'h0000_C003); acc(0, 'h10, 4, 0);
    acc(1, 'h1C, 4, 32'h0000_0005); acc(0, 'h1C, 4, 0);
    acc(1, 'h24, 4, 32'hFFFF_FFF0); acc(0, 'h24, 4, 0);

    tag = "R10";
    acc(1, 'h30, 4, 32'hFFFF_FFFE); acc(0, 'h30, 4, 0);
    acc(1, 'h30, 4, 32'h000C_0001); acc(0, 'h30, 4, 0);

    tag = "R11";
    acc(0, 'h40, 4, 0); acc(1, 'h80, 4, 32'h1234); acc(0, 'h00, 0, 0);
    acc(1, 'h3C, 3, 32'hAA); acc(0, 'h04, 7, 0); acc(0, 'hFF, 1, 0);
    acc(0, 'h3C, 4, 0);

    tag = "R12";
    acc(0, 'h00, 4, 0, 1);
    acc(0, 'h3C, 1, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL %s watchdog expired: got %h expected %h", tag, 32'(cyc), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule